// File: doc/BRIEF.md
# Strip Front-End Pipeline Readout Sequencer

This block drives the digital control lines of a multi-channel strip front-end chip. Each channel of the chip keeps a short ring of analog sample capacitors. While the chip samples, the sequencer moves a single select bit around a ring of `PIPE_DEPTH` slots, one slot per clock. The ring therefore always holds the most recent history of the input. A trigger ends sampling. The sequencer then points the ring select back by a programmable latency, so that the selected slot holds the sample taken when the particle passed. Finally it switches the chip into readout mode.

In readout, a token is loaded into the chip's channel shift register and moved through all `NUM_CH` channels by two non-overlapping phase clocks. After the second phase of each channel, the sequencer gives the downstream ADC a one-cycle strobe together with the index of that channel. When the last channel has been read, the chip returns to sampling with the ring select restarted at slot 0.

Three side controls are also provided. A calibration line normally sits high and falls for one cycle on request, which injects a test charge into the sample captured at that moment. A channel-clear pulse can be timed to a beam-crossing input. A static bleed-path enable is registered and passed to the chip. `PIPE_DEPTH` must be a power of two.

Top module: `strip_pipe_sequencer`

## Requirements
- R1: After reset, and at any time the block is sampling, `samp_o` is 1 and `out_en_o` and `busy_o` are 0. During readout `samp_o` is 0 and `out_en_o` and `busy_o` are 1.
- R2: `pipe_sel_o` always has exactly one bit set. Reset puts that bit at slot 0. While the block samples with no trigger, the bit moves to the next higher slot on every clock and wraps from slot `PIPE_DEPTH-1` to slot 0.
- R3: Suppose a trigger is seen while sampling and the select bit is at slot W. From the next cycle on, the block is busy and `pipe_sel_o` selects slot (W − L) mod `PIPE_DEPTH`, where L is the latency register. The select stays fixed until readout ends.
- R4: The latency register resets to 0. A write (`lat_wr_i`) is taken only while sampling. A write in the same cycle as a trigger affects only later triggers. A write during readout is discarded.
- R5: Readout timing with the default parameters is as follows. The cycle after the trigger is a settle cycle in which no phase is high. Each channel then takes six cycles: phase 1 high for 2 cycles, 1 dead cycle, phase 2 high for 2 cycles, then 1 dead cycle. The two phases are never high together.
- R6: `rd_in_o` (the token loaded into the channel register) is high exactly while phase 1 is high for channel 0, and low at all other times.
- R7: `adc_strobe_o` is high in the last (dead) cycle of each channel, with `adc_ch_o` equal to the channel index. Channels run 0, 1, … up to `NUM_CH-1`, giving exactly `NUM_CH` strobes per readout.
- R8: A trigger during readout has no effect. On the clock after the last channel's final cycle, the block is sampling again with the select bit at slot 0.
- R9: `cal_o` idles at 1. If `cal_fire_i` is high in a sampling cycle with no trigger, `cal_o` is 0 for exactly the next cycle. In any other cycle `cal_fire_i` has no effect.
- R10: If `bunch_i` and `clr_en_i` are both high in a sampling cycle with no trigger, `clr_o` is 1 for exactly the next cycle. Otherwise `clr_o` is 0.
- R11: `bleed_o` equals `bleed_en_i` delayed by one clock, in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_i | input | 1 | Trigger request |
| lat_wr_i | input | 1 | Latency register write enable |
| lat_val_i | input | LAT_W | Latency value to write |
| cal_fire_i | input | 1 | Calibration injection request |
| bunch_i | input | 1 | Beam-crossing marker |
| clr_en_i | input | 1 | Enables channel clear on beam crossing |
| bleed_en_i | input | 1 | Static bleed-path enable |
| samp_o | output | 1 | Combined sample/input-select line, high while sampling |
| out_en_o | output | 1 | Output stage enable, high while not sampling |
| pipe_sel_o | output | PIPE_DEPTH | One-hot ring slot select |
| clr_o | output | 1 | Channel charge clear |
| cal_o | output | 1 | Calibration line, falling edge injects |
| bleed_o | output | 1 | Bleed-path enable to chip |
| rd_in_o | output | 1 | Token into channel shift register |
| rd_ph1_o | output | 1 | Readout phase clock 1 |
| rd_ph2_o | output | 1 | Readout phase clock 2 |
| adc_strobe_o | output | 1 | ADC conversion strobe |
| adc_ch_o | output | CH_W | Channel index for the strobe |
| busy_o | output | 1 | Readout in progress |

## Verification
The collision that matters is a latency write arriving in the same cycle as a trigger. Both act at that edge: one rewinds the select, the other loads the register. The bench provokes this by asserting `lat_wr_i` with a new value together with `trig_i`. It judges the outcome by checking that this readout selects the slot computed with the old latency, and that the next trigger selects the slot computed with the new one. Calibration and clear requests arriving with a trigger, and every request held high during readout, are also checked at the ports for having no effect.

// File: rtl/sps_pkg.sv
package sps_pkg;
    typedef enum logic [1:0] {
        MODE_SAMPLE = 2'd0,
        MODE_SETTLE = 2'd1,
        MODE_READ   = 2'd2
    } mode_e;
endpackage

// File: rtl/sps_onehot.sv
module sps_onehot #(
    parameter int N = 32,
    localparam int W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [W-1:0] idx_i,
    output logic [N-1:0] sel_o
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        assign sel_o[i] = (idx_i == W'(i));
    end
endmodule

// File: rtl/sps_phase_decode.sv
module sps_phase_decode #(
    parameter int PH_LEN  = 2,
    parameter int GAP_LEN = 1,
    localparam int STEP_N = 2 * (PH_LEN + GAP_LEN),
    localparam int STEP_W = $clog2(STEP_N)
) (
    input  logic [STEP_W-1:0] step_i,
    output logic              ph1_o,
    output logic              ph2_o,
    output logic              strobe_o,
    output logic              last_o
);
    localparam int PH2_START = PH_LEN + GAP_LEN;
    localparam int PH2_END   = 2 * PH_LEN + GAP_LEN;

    always_comb begin
        ph1_o    = (step_i < STEP_W'(PH_LEN));
        ph2_o    = (step_i >= STEP_W'(PH2_START)) && (step_i < STEP_W'(PH2_END));
        strobe_o = (step_i == STEP_W'(PH2_END));
        last_o   = (step_i == STEP_W'(STEP_N - 1));
    end
endmodule

// File: rtl/strip_pipe_sequencer.sv
module strip_pipe_sequencer #(
    parameter int PIPE_DEPTH = 32,
    parameter int NUM_CH     = 128,
    parameter int PH_LEN     = 2,
    parameter int GAP_LEN    = 1,
    localparam int LAT_W  = $clog2(PIPE_DEPTH),
    localparam int CH_W   = $clog2(NUM_CH),
    localparam int STEP_N = 2 * (PH_LEN + GAP_LEN),
    localparam int STEP_W = $clog2(STEP_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_i,
    input  logic              lat_wr_i,
    input  logic [LAT_W-1:0]  lat_val_i,
    input  logic              cal_fire_i,
    input  logic              bunch_i,
    input  logic              clr_en_i,
    input  logic              bleed_en_i,
    output logic              samp_o,
    output logic              out_en_o,
    output logic [PIPE_DEPTH-1:0] pipe_sel_o,
    output logic              clr_o,
    output logic              cal_o,
    output logic              bleed_o,
    output logic              rd_in_o,
    output logic              rd_ph1_o,
    output logic              rd_ph2_o,
    output logic              adc_strobe_o,
    output logic [CH_W-1:0]   adc_ch_o,
    output logic              busy_o
);
    import sps_pkg::*;

    typedef struct packed {
        mode_e             mode;
        logic [LAT_W-1:0]  wpos;
        logic [LAT_W-1:0]  rpos;
        logic [LAT_W-1:0]  lat;
        logic [CH_W-1:0]   ch;
        logic [STEP_W-1:0] step;
        logic              cal;
        logic              clr;
        logic              bleed;
    } seq_regs_t;

    seq_regs_t r_q, r_d;

    logic             is_sample, is_read;
    logic             ph1, ph2, strobe, step_last;
    logic [LAT_W-1:0] sel_idx;

    assign is_sample = (r_q.mode == MODE_SAMPLE);
    assign is_read   = (r_q.mode == MODE_READ);

    sps_phase_decode #(
        .PH_LEN  (PH_LEN),
        .GAP_LEN (GAP_LEN)
    ) u_phase (
        .step_i   (r_q.step),
        .ph1_o    (ph1),
        .ph2_o    (ph2),
        .strobe_o (strobe),
        .last_o   (step_last)
    );

    // Ring select shows write slot while sampling, read slot otherwise
    assign sel_idx = is_sample ? r_q.wpos : r_q.rpos;

    sps_onehot #(
        .N (PIPE_DEPTH)
    ) u_sel (
        .idx_i (sel_idx),
        .sel_o (pipe_sel_o)
    );

    always_comb begin
        r_d       = r_q;
        r_d.cal   = 1'b0;
        r_d.clr   = 1'b0;
        r_d.bleed = bleed_en_i;

        unique case (r_q.mode)
            MODE_SAMPLE: begin
                if (lat_wr_i) begin
                    r_d.lat = lat_val_i;
                end
                if (trig_i) begin
                    // Stop writing; rewind by the latency in force now
                    r_d.mode = MODE_SETTLE;
                    r_d.rpos = r_q.wpos - r_q.lat;
                end else begin
                    r_d.wpos = r_q.wpos + 1'b1;
                    r_d.cal  = cal_fire_i;
                    r_d.clr  = bunch_i & clr_en_i;
                end
            end
            MODE_SETTLE: begin
                r_d.mode = MODE_READ;
                r_d.ch   = '0;
                r_d.step = '0;
            end
            MODE_READ: begin
                if (step_last) begin
                    r_d.step = '0;
                    if (r_q.ch == CH_W'(NUM_CH - 1)) begin
                        r_d.mode = MODE_SAMPLE;
                        r_d.wpos = '0;
                        r_d.ch   = '0;
                    end else begin
                        r_d.ch = r_q.ch + 1'b1;
                    end
                end else begin
                    r_d.step = r_q.step + 1'b1;
                end
            end
            default: begin
                r_d.mode = MODE_SAMPLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.mode  <= MODE_SAMPLE;
            r_q.wpos  <= '0;
            r_q.rpos  <= '0;
            r_q.lat   <= '0;
            r_q.ch    <= '0;
            r_q.step  <= '0;
            r_q.cal   <= 1'b0;
            r_q.clr   <= 1'b0;
            r_q.bleed <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign samp_o       = is_sample;
    assign out_en_o     = !is_sample;
    assign busy_o       = !is_sample;
    assign clr_o        = r_q.clr;
    assign cal_o        = !r_q.cal;
    assign bleed_o      = r_q.bleed;
    assign rd_ph1_o     = is_read & ph1;
    assign rd_ph2_o     = is_read & ph2;
    assign rd_in_o      = is_read & ph1 & (r_q.ch == '0);
    assign adc_strobe_o = is_read & strobe;
    assign adc_ch_o     = r_q.ch;
endmodule

// File: rtl/sps_checker.sv
module sps_checker #(
    parameter int PIPE_DEPTH = 32
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  trig_i,
    input logic                  samp_o,
    input logic                  busy_o,
    input logic [PIPE_DEPTH-1:0] pipe_sel_o,
    input logic                  rd_ph1_o,
    input logic                  rd_ph2_o,
    input logic                  adc_strobe_o,
    input logic                  cal_o,
    input logic                  clr_o
);
    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(pipe_sel_o) == 1); // R2

    AST_RING_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (samp_o && !trig_i) |=> (pipe_sel_o == {$past(pipe_sel_o[PIPE_DEPTH-2:0]), $past(pipe_sel_o[PIPE_DEPTH-1])})); // R2

    AST_TRIG_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (samp_o && trig_i) |=> (busy_o && !samp_o)); // R3

    AST_SEL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> (!busy_o || $stable(pipe_sel_o))); // R3

    AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_ph1_o && rd_ph2_o)); // R5

    AST_STROBE_AFTER_PH2: assert property (@(posedge clk) disable iff (!rst_n)
        adc_strobe_o |-> (!rd_ph1_o && !rd_ph2_o && $past(rd_ph2_o))); // R7

    AST_CAL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cal_o) |=> cal_o); // R9

    AST_CLR_IN_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        clr_o |-> samp_o); // R10
endmodule

bind strip_pipe_sequencer sps_checker #(
    .PIPE_DEPTH (PIPE_DEPTH)
) u_sps_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .trig_i       (trig_i),
    .samp_o       (samp_o),
    .busy_o       (busy_o),
    .pipe_sel_o   (pipe_sel_o),
    .rd_ph1_o     (rd_ph1_o),
    .rd_ph2_o     (rd_ph2_o),
    .adc_strobe_o (adc_strobe_o),
    .cal_o        (cal_o),
    .clr_o        (clr_o)
);

// File: tb/strip_pipe_sequencer_bench.sv
`timescale 1ns/100ps
module strip_pipe_sequencer_bench;
    localparam int DEPTH = 32;
    localparam int NCH   = 128;
    localparam int STEPS = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trig_i = 1'b0, lat_wr_i = 1'b0, cal_fire_i = 1'b0;
    logic        bunch_i = 1'b0, clr_en_i = 1'b0, bleed_en_i = 1'b0;
    logic [4:0]  lat_val_i = '0;
    logic        samp_o, out_en_o, clr_o, cal_o, bleed_o;
    logic        rd_in_o, rd_ph1_o, rd_ph2_o, adc_strobe_o, busy_o;
    logic [31:0] pipe_sel_o;
    logic [6:0]  adc_ch_o;

    int n_tests = 0;
    int n_fail  = 0;
    int exp_w   = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    strip_pipe_sequencer u_strip_pipe_sequencer (
        .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .lat_wr_i(lat_wr_i),
        .lat_val_i(lat_val_i), .cal_fire_i(cal_fire_i), .bunch_i(bunch_i),
        .clr_en_i(clr_en_i), .bleed_en_i(bleed_en_i), .samp_o(samp_o),
        .out_en_o(out_en_o), .pipe_sel_o(pipe_sel_o), .clr_o(clr_o),
        .cal_o(cal_o), .bleed_o(bleed_o), .rd_in_o(rd_in_o),
        .rd_ph1_o(rd_ph1_o), .rd_ph2_o(rd_ph2_o), .adc_strobe_o(adc_strobe_o),
        .adc_ch_o(adc_ch_o), .busy_o(busy_o)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // One sampling clock with no trigger; ring model advances
    task automatic samp_tick();
        tick();
        exp_w = (exp_w + 1) % DEPTH;
        chk("R2 ring slot", pipe_sel_o, 64'(32'd1 << exp_w));
        chk("R1 sampling levels", {samp_o, out_en_o, busy_o}, 3'b100);
    endtask

    // Trigger now, check full readout. lat_now is the latency in force.
    task automatic run_readout(input int lat_now, input bit wr, input int wr_val, input bit noisy);
        int w;
        int rd;
        int strobes;
        w = exp_w;
        rd = (w - lat_now + DEPTH) % DEPTH;
        strobes = 0;
        trig_i = 1'b1;
        lat_wr_i = wr;
        lat_val_i = 5'(wr_val);
        cal_fire_i = noisy;
        bunch_i = noisy;
        clr_en_i = noisy;
        tick();
        trig_i = noisy;
        lat_wr_i = noisy;
        lat_val_i = 5'(~lat_now);
        chk("R3 busy after trigger", {samp_o, out_en_o, busy_o}, 3'b011);
        chk("R3 read slot", pipe_sel_o, 64'(32'd1 << rd));
        chk("R5 settle no phase", {rd_ph1_o, rd_ph2_o, adc_strobe_o, rd_in_o}, 4'b0000);
        chk("R9 cal with trigger suppressed", cal_o, 1'b1);
        chk("R10 clr with trigger suppressed", clr_o, 1'b0);
        for (int t = 2; t < 2 + NCH * STEPS; t++) begin
            int s;
            int c;
            logic [3:0] ev;
            tick();
            s = (t - 2) % STEPS;
            c = (t - 2) / STEPS;
            ev[3] = (s < 2);
            ev[2] = (s == 3) || (s == 4);
            ev[1] = (s == 5);
            ev[0] = (s < 2) && (c == 0);
            chk("R5 R6 phase pattern", {rd_ph1_o, rd_ph2_o, adc_strobe_o, rd_in_o}, ev);
            if (adc_strobe_o) begin
                strobes++;
                chk("R7 strobe channel", adc_ch_o, c);
            end
            if (noisy) begin
                chk("R8 trigger ignored while busy", {busy_o, pipe_sel_o}, {1'b1, 32'd1 << rd});
                chk("R9 cal ignored while busy", cal_o, 1'b1);
                chk("R10 clr ignored while busy", clr_o, 1'b0);
            end
        end
        chk("R7 strobe count", strobes, NCH);
        tick();
        trig_i = 1'b0; lat_wr_i = 1'b0; cal_fire_i = 1'b0; bunch_i = 1'b0; clr_en_i = 1'b0;
        exp_w = 0;
        chk("R8 back to sampling", {samp_o, busy_o}, 2'b10);
        chk("R8 restart slot 0", pipe_sel_o, 64'd1);
    endtask

    initial begin
        #(5.0 * 190000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        chk("R1 reset levels", {samp_o, out_en_o, busy_o}, 3'b100);
        chk("R2 reset slot", pipe_sel_o, 64'd1);
        chk("R9 cal idle", cal_o, 1'b1);
        chk("R10 clr idle", clr_o, 1'b0);
        chk("R5 phases idle", {rd_ph1_o, rd_ph2_o, adc_strobe_o, rd_in_o}, 4'b0000);
        rst_n = 1'b1;
        exp_w = 0;

        // R2 rotation with wrap
        for (int k = 0; k < 40; k++) samp_tick();

        // R11 bleed follows one cycle later
        bleed_en_i = 1'b1;
        samp_tick();
        chk("R11 bleed high", bleed_o, 1'b1);
        bleed_en_i = 1'b0;
        samp_tick();
        chk("R11 bleed low", bleed_o, 1'b0);

        // R9 calibration pulse
        cal_fire_i = 1'b1;
        samp_tick();
        cal_fire_i = 1'b0;
        chk("R9 cal low one cycle", cal_o, 1'b0);
        samp_tick();
        chk("R9 cal back high", cal_o, 1'b1);

        // R10 clear on beam crossing
        bunch_i = 1'b1; clr_en_i = 1'b1;
        samp_tick();
        bunch_i = 1'b0;
        chk("R10 clr pulse", clr_o, 1'b1);
        samp_tick();
        chk("R10 clr single", clr_o, 1'b0);
        bunch_i = 1'b1; clr_en_i = 1'b0;
        samp_tick();
        bunch_i = 1'b0;
        chk("R10 clr disabled", clr_o, 1'b0);

        // R4 reset latency 0
        run_readout(0, 1'b0, 0, 1'b0);

        // R3 sweep every latency at varying trigger slots
        for (int l = 0; l < DEPTH; l++) begin
            lat_wr_i = 1'b1;
            lat_val_i = 5'(l);
            samp_tick();
            lat_wr_i = 1'b0;
            for (int k = 0; k < (l * 7) % 37; k++) samp_tick();
            run_readout(l, 1'b0, 0, (l % 4) == 1);
        end

        // R4 collision: write with trigger uses old latency (31), new (9) next time
        samp_tick();
        run_readout(31, 1'b1, 9, 1'b0);
        for (int k = 0; k < 5; k++) samp_tick();
        run_readout(9, 1'b0, 0, 1'b0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule